// File: doc/BRIEF.md
# LCD Backplane Frame Sequencer with Cascade Alignment

This block paces the time-multiplexed drive of a segment display. It walks through the backplane time slots that the selected multiplex ratio calls for. In each slot it addresses one row of the display memory and presents that row as a vector of logical on/off states, one bit per segment. Every slot is split into two halves so that the analog drive stage downstream can flip polarity and keep the average voltage across each segment at zero.

Several copies of the block can share one open-drain, active-low alignment line. A copy pulls the line low for the whole of its final slot and watches the line the rest of the time. When a copy sees the line fall while it is in an earlier slot, it jumps to its own final slot, at the cycle offset the copy that pulled has reached. The first copy to pull therefore sets the frame phase for the whole chain. The block can also swap to the upper memory rows in the two modes that use at most two rows, and it can blank the whole display for half of each blink period.

Top module: `lcd_frame_seq`

## Requirements
- R1: While rst_ni is low at a clock edge, the block clears its state: slot_o is 0 and seg_on_o is all zeros.
- R2: mode_i selects the slots per frame: 0 gives 1 slot, 1 gives 2 slots, 2 gives 3 slots, 3 gives 4 slots. Each slot lasts SLOT_CYCLES clock cycles. slot_o counts up from 0 and wraps to 0 after the last slot, and the pattern repeats every frame.
- R3: half_o is 0 during the first SLOT_CYCLES/2 cycles of a slot and 1 during the second half.
- R4: With bank_i low, or in modes 2 and 3 whatever bank_i is, ram_row_o equals slot_o.
- R5: With bank_i high, mode 0 addresses row 2, and mode 1 addresses row 2 in slot 0 and row 3 in slot 1.
- R6: One clock after ram_row_o changes, seg_on_o shows the ram_data_i value read for that row, unless blinking blanks it.
- R7: sync_pull_o is 1 exactly while slot_o is the last slot of the current mode, and 0 in every other slot.
- R8: The line sync_in_ni passes through a two-stage synchronizer. When the line falls while the block is not in its last slot, the third clock edge after the fall puts the block into its last slot at cycle 3 of that slot. From there the slot runs for SLOT_CYCLES-3 more cycles.
- R9: A fall of the line that the block sees while it is in its last slot, including the one its own pull causes, does not change the slot timing.
- R10: blink_rate_i sets the blink period: 1 gives BLINK_UNIT cycles, 2 gives 2*BLINK_UNIT cycles, 3 gives 4*BLINK_UNIT cycles. During the second half of each period, seg_on_o is all zeros for exactly period/2 consecutive cycles.
- R11: With blink_rate_i set to 0, seg_on_o is never blanked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| mode_i | input | 2 | Multiplex ratio: 0 static, 1 two-way, 2 three-way, 3 four-way |
| bank_i | input | 1 | Selects the upper memory rows in modes 0 and 1 |
| blink_rate_i | input | 2 | 0 off; 1, 2, 3 give blink periods of 1, 2, 4 times BLINK_UNIT |
| ram_data_i | input | SEGS | Display memory row read for ram_row_o |
| sync_in_ni | input | 1 | Shared alignment line, active low |
| ram_row_o | output | 2 | Memory row addressed in the current slot |
| slot_o | output | 2 | Active backplane slot index |
| half_o | output | 1 | Polarity half within the slot |
| seg_on_o | output | SEGS | Logical on/off state for each segment |
| sync_pull_o | output | 1 | Pulls the alignment line low while set |

## Verification
On every cycle, the assertions check the following properties of slot timing:
- A slot holds until its last cycle unless a jump occurs.
- The last slot wraps to slot 0.
- A fall seen outside the last slot lands on the last slot at cycle 3.
- The synchronized fall detector pulses for a single cycle.
- The pull starts only in the first half of a slot.
- The bank swap addresses the right row in static mode.
- Blanking forces the segments off and never happens with the blink rate at 0.

The bench scenarios cover what has to be counted over a longer span:
- The slot sequence over several frames for each mode and bank setting, including the bank being ignored in the three-way and four-way modes.
- The segment data of each row.
- The exact cycle of the re-alignment after another device pulls the line.
- The length of the blanked stretch for each blink rate.

// File: rtl/lcdseq_pkg.sv
// Shared types for the LCD frame sequencer.
// Assumes a 2-bit row index, so four memory rows at most.
package lcdseq_pkg;
    typedef enum logic [1:0] {
        MUX_STATIC = 2'd0,
        MUX_TWO    = 2'd1,
        MUX_THREE  = 2'd2,
        MUX_FOUR   = 2'd3
    } mux_mode_t;

    localparam int ROW_W = 2;
endpackage

// File: rtl/lcdseq_sync_in.sv
// Alignment line receiver: a two-flop synchronizer, then a one-cycle
// pulse on each falling edge of the line.
// Assumes the line is active low; the stored bits mean "line asserted".
module lcdseq_sync_in (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic line_ni,
    output logic fall_o
);
    logic meta_q, stab_q, prev_q;

    // Synchronize the asserted level and keep one cycle of history.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            meta_q <= 1'b0;
            stab_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= ~line_ni;
            stab_q <= meta_q;
            prev_q <= stab_q;
        end
    end

    assign fall_o = stab_q & ~prev_q;

    p_fall_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fall_o |=> !fall_o);
endmodule

// File: rtl/lcdseq_slot_timer.sv
// Slot timer: counts cycles within a slot and slots within a frame.
// A synchronized fall seen outside the last slot forces the last slot
// at cycle JUMP_CYC. That is the offset of the device that pulled the
// line, since the fall reaches this block three edges late.
// Assumes SLOT_CYCLES is even and at least 8.
module lcdseq_slot_timer
    import lcdseq_pkg::*;
#(
    parameter int SLOT_CYCLES = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [ROW_W-1:0] last_i,
    input  logic             fall_i,
    output logic [ROW_W-1:0] slot_o,
    output logic             half_o,
    output logic             last_slot_o
);
    localparam int CW = $clog2(SLOT_CYCLES);
    localparam logic [CW-1:0] CYC_END  = CW'(SLOT_CYCLES - 1);
    localparam logic [CW-1:0] CYC_HALF = CW'(SLOT_CYCLES / 2);
    localparam logic [CW-1:0] JUMP_CYC = CW'(3);

    logic [CW-1:0]    cyc_q;
    logic [ROW_W-1:0] slot_q;

    assign last_slot_o = (slot_q == last_i);

    // Advance the cycle and slot counters, or re-align on an outside fall.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cyc_q  <= '0;
            slot_q <= '0;
        end else if (fall_i && !last_slot_o) begin
            cyc_q  <= JUMP_CYC;
            slot_q <= last_i;
        end else if (cyc_q == CYC_END) begin
            cyc_q  <= '0;
            slot_q <= (slot_q >= last_i) ? '0 : slot_q + 1'b1;
        end else begin
            cyc_q <= cyc_q + 1'b1;
        end
    end

    assign slot_o = slot_q;
    assign half_o = (cyc_q >= CYC_HALF);

    p_slot_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cyc_q != CYC_END && !fall_i) |=> $stable(slot_q));
    p_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cyc_q == CYC_END && last_slot_o) |=> (slot_q == '0));
    p_jump_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fall_i && !last_slot_o) |=> (slot_q == $past(last_i) && cyc_q == JUMP_CYC));
endmodule

// File: rtl/lcdseq_blink.sv
// Blink timer: a free-running period counter that blanks the display
// during the second half of each period. Rate 0 stops the counter and
// turns blanking off.
// Assumes BLINK_UNIT is even.
module lcdseq_blink #(
    parameter int BLINK_UNIT = 768
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [1:0] rate_i,
    output logic       blank_o
);
    localparam int BW = $clog2(4 * BLINK_UNIT);

    logic [BW-1:0] cnt_q;
    logic [BW-1:0] period;

    // Pick the period length for the selected rate.
    always_comb begin
        case (rate_i)
            2'd1:    period = BW'(BLINK_UNIT);
            2'd2:    period = BW'(2 * BLINK_UNIT);
            default: period = BW'(4 * BLINK_UNIT);
        endcase
    end

    // Count through one period; hold at zero while blinking is off.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || rate_i == 2'd0) begin
            cnt_q <= '0;
        end else if (cnt_q >= period - 1'b1) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign blank_o = (rate_i != 2'd0) && (cnt_q >= (period >> 1));

    p_blink_off_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rate_i == 2'd0) |-> !blank_o);
endmodule

// File: rtl/lcd_frame_seq.sv
// LCD frame sequencer top. It ties together:
// - the alignment receiver,
// - the slot timer,
// - the blink timer,
// - the row mapping, including the bank swap,
// - the segment register.
// Assumes ram_data_i is a combinational read of row ram_row_o.
module lcd_frame_seq
    import lcdseq_pkg::*;
#(
    parameter int SEGS        = 40,
    parameter int SLOT_CYCLES = 16,
    parameter int BLINK_UNIT  = 768
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [1:0]       mode_i,
    input  logic             bank_i,
    input  logic [1:0]       blink_rate_i,
    input  logic [SEGS-1:0]  ram_data_i,
    input  logic             sync_in_ni,
    output logic [ROW_W-1:0] ram_row_o,
    output logic [ROW_W-1:0] slot_o,
    output logic             half_o,
    output logic [SEGS-1:0]  seg_on_o,
    output logic             sync_pull_o
);
    mux_mode_t        mode;
    logic             fall;
    logic             last_slot;
    logic             blank;
    logic [ROW_W-1:0] slot;
    logic [SEGS-1:0]  seg_q;

    assign mode = mux_mode_t'(mode_i);

    lcdseq_sync_in u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .line_ni (sync_in_ni),
        .fall_o  (fall)
    );

    lcdseq_slot_timer #(.SLOT_CYCLES(SLOT_CYCLES)) u_timer (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .last_i      (mode_i),
        .fall_i      (fall),
        .slot_o      (slot),
        .half_o      (half_o),
        .last_slot_o (last_slot)
    );

    lcdseq_blink #(.BLINK_UNIT(BLINK_UNIT)) u_blink (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .rate_i  (blink_rate_i),
        .blank_o (blank)
    );

    // Map the slot to a memory row; the bank swaps to the upper rows in the two low modes.
    always_comb begin
        case (mode)
            MUX_STATIC: ram_row_o = bank_i ? 2'd2 : 2'd0;
            MUX_TWO:    ram_row_o = {bank_i, slot[0]};
            default:    ram_row_o = slot;
        endcase
    end

    // Register the row read, forced off while blanked.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            seg_q <= '0;
        end else begin
            seg_q <= blank ? '0 : ram_data_i;
        end
    end

    assign seg_on_o    = seg_q;
    assign slot_o      = slot;
    assign sync_pull_o = last_slot;

    p_blank_seg_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        blank |=> (seg_on_o == '0));
    p_bank_row_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode == MUX_STATIC && bank_i) |-> (ram_row_o == 2'd2));
    p_pull_rise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(sync_pull_o) && $stable(mode_i)) |-> !half_o);
endmodule

// File: tb/lcd_frame_seq_test.sv
module lcd_frame_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int SEGS  = 40;
    localparam int SLOTC = 8;
    localparam int UNIT  = 768;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      mode = 2'd3;
    logic            bank = 1'b0;
    logic [1:0]      rate = 2'd0;
    logic            ext_pull = 1'b0;
    logic [SEGS-1:0] mem [4];
    logic [1:0]      ram_row, slot;
    logic            half, pull;
    logic [SEGS-1:0] seg_on;
    logic            line_n;
    int              checks = 0;
    int              errors = 0;
    bit              done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign line_n = ~(pull | ext_pull);

    lcd_frame_seq #(.SEGS(SEGS), .SLOT_CYCLES(SLOTC), .BLINK_UNIT(UNIT)) uut (
        .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .bank_i(bank),
        .blink_rate_i(rate), .ram_data_i(mem[ram_row]), .sync_in_ni(line_n),
        .ram_row_o(ram_row), .slot_o(slot), .half_o(half),
        .seg_on_o(seg_on), .sync_pull_o(pull)
    );

    // Table entries: {mode[13:12], bank[11], slots[10:8], row of slot k at [2k+1:2k]}.
    localparam logic [13:0] VEC [8] = '{
        {2'd0, 1'b0, 3'd1, 8'b00_00_00_00},
        {2'd0, 1'b1, 3'd1, 8'b00_00_00_10},
        {2'd1, 1'b0, 3'd2, 8'b00_00_01_00},
        {2'd1, 1'b1, 3'd2, 8'b00_00_11_10},
        {2'd2, 1'b0, 3'd3, 8'b00_10_01_00},
        {2'd2, 1'b1, 3'd3, 8'b00_10_01_00},
        {2'd3, 1'b0, 3'd4, 8'b11_10_01_00},
        {2'd3, 1'b1, 3'd4, 8'b11_10_01_00}
    };

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic restart(input logic [1:0] m, input logic b, input logic [1:0] r);
        @(negedge clk);
        rst_n = 1'b0;
        mode = m;
        bank = b;
        rate = r;
        ext_pull = 1'b0;
        step(3);
        rst_n = 1'b1;
    endtask

    initial begin
        int maxrun, run, per, zeros;
        int nsl;
        logic [1:0] erow;
        mem[0] = 40'hA5_0F0F_1234;
        mem[1] = 40'h5A_F0F0_8765;
        mem[2] = 40'h3C_1111_BEEF;
        mem[3] = 40'hC3_EEEE_0042;

        // R1: reset state, checked while reset is held.
        step(3);
        check(slot == 2'd0, "R1 slot in reset", 64'(slot), 64'd0);
        check(seg_on == '0, "R1 seg in reset", 64'(seg_on), 64'd0);
        check(pull == 1'b0, "R1 pull in reset (mode 3)", 64'(pull), 64'd0);

        // Table walk: slot sequence, halves, row mapping, data and pull over three frames.
        for (int v = 0; v < 8; v++) begin
            restart(VEC[v][13:12], VEC[v][11], 2'd0);
            nsl = int'(VEC[v][10:8]);
            step(1);
            for (int f = 0; f < 3; f++) begin
                for (int k = 0; k < nsl; k++) begin
                    erow = VEC[v][2*k +: 2];
                    check(slot == 2'(k), "R2 R9 slot sequence", 64'(slot), 64'(k));
                    check(half == 1'b0, "R3 first half", 64'(half), 64'd0);
                    step(SLOTC/2);
                    check(half == 1'b1, "R3 second half", 64'(half), 64'd1);
                    check(ram_row == erow, "R4 R5 row mapping", 64'(ram_row), 64'(erow));
                    check(seg_on == mem[erow], "R6 segment data", 64'(seg_on), 64'(mem[erow]));
                    check(pull == (k == nsl - 1), "R7 pull in last slot", 64'(pull), 64'(k == nsl - 1));
                    step(SLOTC/2);
                end
            end
        end

        // R8: another device pulls the line while this block is in slot 1, cycle 2.
        restart(2'd3, 1'b0, 2'd0);
        step(SLOTC + 2);
        ext_pull = 1'b1;
        step(3);
        check(slot == 2'd3, "R8 jump to last slot", 64'(slot), 64'd3);
        check(half == 1'b0, "R8 jump lands at cycle 3", 64'(half), 64'd0);
        check(pull == 1'b1, "R8 pull after jump", 64'(pull), 64'd1);
        ext_pull = 1'b0;
        step(1);
        check(half == 1'b1, "R8 cycle 4 in second half", 64'(half), 64'd1);
        step(3);
        check(slot == 2'd3, "R8 last slot end", 64'(slot), 64'd3);
        step(1);
        check(slot == 2'd0, "R8 wrap after jump", 64'(slot), 64'd0);
        step(SLOTC);
        check(slot == 2'd1, "R8 R9 frame continues", 64'(slot), 64'd1);

        // R10: longest blanked run equals half the period for each rate.
        mem[0] = '1; mem[1] = '1; mem[2] = '1; mem[3] = '1;
        for (int r = 1; r < 4; r++) begin
            per = UNIT << (r - 1);
            restart(2'd3, 1'b0, 2'(r));
            maxrun = 0;
            run = 0;
            for (int c = 0; c < 2 * per + 8; c++) begin
                step(1);
                if (seg_on == '0) run++; else run = 0;
                if (run > maxrun) maxrun = run;
            end
            check(maxrun == per / 2, "R10 blank length", 64'(maxrun), 64'(per / 2));
        end

        // R11: blinking off never blanks.
        restart(2'd1, 1'b1, 2'd0);
        zeros = 0;
        for (int c = 0; c < 2000; c++) begin
            step(1);
            if (seg_on == '0) zeros++;
        end
        check(zeros == 0, "R11 no blanking at rate 0", 64'(zeros), 64'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule